// File: doc/BRIEF.md
# Write Protection Command Decoder

This block sits between the latched write-cycle stream of a byte-wide non-volatile memory and its page programming engine. It looks for fixed address/data unlock sequences among the writes. Depending on what it finds, it forwards ordinary data writes, lets a single page load through while protection is on, clears protection, starts a timed whole-array erase, or moves into an identification mode. In that mode, reads of the two lowest addresses return a manufacturer code and a device code.

The protection flag is sticky. It comes out of reset enabled, or as the reset parameter chooses. Only the six-write disable sequence clears it. The three-write arm prefix sets it again. Every command address, command data byte, identification code and the erase duration (in clock cycles) is a parameter. The defaults are the conventional 5555h/2AAAh unlock pair with data AAh/55h. The command bytes are A0h arm, 80h extend, F0h leave ID, 20h disable, 10h erase and 60h enter ID.

Top module: `wprot_cmd_decoder`

## Requirements
- R1: After reset, prot_on equals the PROT_INIT parameter (default 1), and armed, id_mode, pass_valid, erase_start and erase_active are 0.
- R2: While prot_on is 1 and armed is 0, no write is forwarded: pass_valid stays 0.
- R3: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h set armed and prot_on one cycle after the last of them. While armed is 1, every accepted write is forwarded. armed clears on the first cycle in which busy is seen rising.
- R4: The six writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/20h clear prot_on. After that, an accepted write that matches no command step appears on pass_valid/pass_addr/pass_data one cycle later, with the same address and data.
- R5: A write that does not match the next expected step returns the matcher to its first step and is not re-examined as a first step. That write is forwarded when prot_on is 0. Writes consumed as matching command steps are never forwarded.
- R6: The six writes ending in 5555h/10h (with 80h as the third) give a one-cycle erase_start pulse. erase_active rises in the same cycle and stays high for exactly ERASE_CYCLES cycles.
- R7: A write presented while busy or erase_active is 1 is ignored: it is not forwarded and it leaves the matcher's progress unchanged.
- R8: The six writes ending in 5555h/60h set id_mode. While id_mode is 1, id_rd_valid/id_rd_data answer rd_addr one cycle later: 0000h gives DAh, 0001h gives C8h, and any other address gives id_rd_valid 0.
- R9: The writes 5555h/AAh, 2AAAh/55h, 5555h/F0h clear id_mode, after which id_rd_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A latched write cycle is present |
| wr_addr | input | 16 | Address of the write |
| wr_data | input | 8 | Data of the write |
| busy | input | 1 | Page engine is programming |
| rd_addr | input | 16 | Read address, for the identification remap |
| pass_valid | output | 1 | Forwarded data write to the page engine |
| pass_addr | output | 16 | Forwarded address |
| pass_data | output | 8 | Forwarded data |
| armed | output | 1 | One page load is permitted under protection |
| prot_on | output | 1 | Software write protection enabled |
| id_mode | output | 1 | Identification mode active |
| id_rd_valid | output | 1 | The current read is replaced by an ID code |
| id_rd_data | output | 8 | ID code for the read |
| erase_start | output | 1 | One-cycle pulse that starts the whole-array erase |
| erase_active | output | 1 | Erase timer running |

## Verification
The sixth write of the erase sequence can arrive in the same cycle that busy rises. The bench provokes this by driving both on one edge. It judges the outcome by seeing no erase_start pulse, and then, once busy drops, by a single repeated final write that does start the erase, which shows the matcher held its place. The erase window itself is also crossed by a write held valid throughout: the bench counts the high cycles of erase_active and confirms that nothing is forwarded in any of them.

// File: rtl/wpcd_pkg.sv
package wpcd_pkg;
  typedef enum logic [2:0] {
    ST_UNL1, ST_UNL2, ST_CMD1, ST_UNL3, ST_UNL4, ST_CMD2
  } step_t;

  typedef struct packed {
    logic arm;
    logic dis;
    logic erase;
    logic id_enter;
    logic id_exit;
  } cmd_ev_t;
endpackage

// File: rtl/wpcd_matcher.sv
module wpcd_matcher
  import wpcd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADDR_A = 'h5555,
  parameter logic [AW-1:0] ADDR_B = 'h2AAA,
  parameter logic [DW-1:0] D_UNL1 = 'hAA,
  parameter logic [DW-1:0] D_UNL2 = 'h55,
  parameter logic [DW-1:0] D_ARM  = 'hA0,
  parameter logic [DW-1:0] D_EXT  = 'h80,
  parameter logic [DW-1:0] D_IDX  = 'hF0,
  parameter logic [DW-1:0] D_DIS  = 'h20,
  parameter logic [DW-1:0] D_ERS  = 'h10,
  parameter logic [DW-1:0] D_IDE  = 'h60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          hit,
  output cmd_ev_t       ev
);
  step_t step, step_nxt;
  logic  match;

  always_comb begin
    match    = 1'b0;
    step_nxt = ST_UNL1;
    ev       = '0;
    unique case (step)
      ST_UNL1: begin match = (addr == ADDR_A) && (data == D_UNL1); step_nxt = ST_UNL2; end
      ST_UNL2: begin match = (addr == ADDR_B) && (data == D_UNL2); step_nxt = ST_CMD1; end
      ST_CMD1: begin
        match    = (addr == ADDR_A) && (data == D_ARM || data == D_EXT || data == D_IDX);
        step_nxt = (data == D_EXT) ? ST_UNL3 : ST_UNL1;
        ev.arm     = take && match && (data == D_ARM);
        ev.id_exit = take && match && (data == D_IDX);
      end
      ST_UNL3: begin match = (addr == ADDR_A) && (data == D_UNL1); step_nxt = ST_UNL4; end
      ST_UNL4: begin match = (addr == ADDR_B) && (data == D_UNL2); step_nxt = ST_CMD2; end
      ST_CMD2: begin
        match    = (addr == ADDR_A) && (data == D_DIS || data == D_ERS || data == D_IDE);
        step_nxt = ST_UNL1;
        ev.dis      = take && match && (data == D_DIS);
        ev.erase    = take && match && (data == D_ERS);
        ev.id_enter = take && match && (data == D_IDE);
      end
      default: begin match = 1'b0; step_nxt = ST_UNL1; end
    endcase
    hit = take && match;
  end

  always_ff @(posedge clk) begin
    if (rst)       step <= ST_UNL1;
    else if (take) step <= match ? step_nxt : ST_UNL1;
  end
endmodule

// File: rtl/wpcd_erase_timer.sv
module wpcd_erase_timer #(
  parameter int CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      cnt    <= CW'(CYCLES - 1);
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wpcd_id_remap.sv
module wpcd_id_remap #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [DW-1:0] MFR_CODE = 'hDA,
  parameter logic [DW-1:0] DEV_CODE = 'hC8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_mode,
  input  logic [AW-1:0] rd_addr,
  output logic          id_rd_valid,
  output logic [DW-1:0] id_rd_data
);
  logic low_pair;
  assign low_pair = (rd_addr[AW-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      id_rd_valid <= 1'b0;
      id_rd_data  <= '0;
    end else begin
      id_rd_valid <= id_mode && low_pair;
      id_rd_data  <= rd_addr[0] ? DEV_CODE : MFR_CODE;
    end
  end
endmodule

// File: rtl/wprot_cmd_decoder.sv
module wprot_cmd_decoder
  import wpcd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic PROT_INIT = 1'b1,
  parameter int ERASE_CYCLES = 10_000_000,
  parameter logic [DW-1:0] MFR_CODE = 'hDA,
  parameter logic [DW-1:0] DEV_CODE = 'hC8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  input  logic [AW-1:0] rd_addr,
  output logic          pass_valid,
  output logic [AW-1:0] pass_addr,
  output logic [DW-1:0] pass_data,
  output logic          armed,
  output logic          prot_on,
  output logic          id_mode,
  output logic          id_rd_valid,
  output logic [DW-1:0] id_rd_data,
  output logic          erase_start,
  output logic          erase_active
);
  logic    take, m_take, hit, busy_q;
  cmd_ev_t ev;

  assign take   = wr_valid && !busy && !erase_active;
  assign m_take = take && !armed;

  wpcd_matcher #(.AW(AW), .DW(DW)) u_match (
    .clk(clk), .rst(rst), .take(m_take), .addr(wr_addr), .data(wr_data),
    .hit(hit), .ev(ev)
  );

  wpcd_erase_timer #(.CYCLES(ERASE_CYCLES)) u_erase (
    .clk(clk), .rst(rst), .start(ev.erase), .active(erase_active)
  );

  wpcd_id_remap #(.AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk(clk), .rst(rst), .id_mode(id_mode), .rd_addr(rd_addr),
    .id_rd_valid(id_rd_valid), .id_rd_data(id_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_on     <= PROT_INIT;
      armed       <= 1'b0;
      id_mode     <= 1'b0;
      pass_valid  <= 1'b0;
      pass_addr   <= '0;
      pass_data   <= '0;
      erase_start <= 1'b0;
      busy_q      <= 1'b0;
    end else begin
      busy_q      <= busy;
      erase_start <= ev.erase;
      pass_valid  <= take && (armed || (!hit && !prot_on));
      if (take) begin
        pass_addr <= wr_addr;
        pass_data <= wr_data;
      end
      if (ev.arm) begin
        armed   <= 1'b1;
        prot_on <= 1'b1;
      end else begin
        if (busy && !busy_q) armed <= 1'b0;
        if (ev.dis) prot_on <= 1'b0;
      end
      if (ev.id_enter)     id_mode <= 1'b1;
      else if (ev.id_exit) id_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/wpcd_checker.sv
module wpcd_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          busy,
  input logic          pass_valid,
  input logic          armed,
  input logic          prot_on,
  input logic          id_mode,
  input logic          id_rd_valid,
  input logic          erase_start,
  input logic          erase_active
);
  assert_pass_source_R7: assert property (@(posedge clk) disable iff (rst)
    pass_valid |-> ($past(wr_valid) && !$past(busy)));

  assert_no_pass_in_erase_R7: assert property (@(posedge clk) disable iff (rst)
    !(pass_valid && erase_active));

  assert_erase_runs_R6: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> erase_active);

  assert_erase_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);

  assert_id_gate_R8: assert property (@(posedge clk) disable iff (rst)
    id_rd_valid |-> $past(id_mode));

  assert_prot_clear_by_write_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(prot_on) |-> $past(wr_valid));

  assert_arm_sets_prot_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> prot_on);
endmodule

bind wprot_cmd_decoder wpcd_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .busy(busy),
  .pass_valid(pass_valid), .armed(armed), .prot_on(prot_on),
  .id_mode(id_mode), .id_rd_valid(id_rd_valid),
  .erase_start(erase_start), .erase_active(erase_active)
);

// File: tb/wprot_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module wprot_cmd_decoder_tb_top;
  localparam int ERASE_N = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [15:0] rd_addr = 16'h8000;
  logic        pass_valid, armed, prot_on, id_mode, id_rd_valid, erase_start, erase_active;
  logic [15:0] pass_addr;
  logic [7:0]  pass_data, id_rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wprot_cmd_decoder #(.ERASE_CYCLES(ERASE_N)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .pass_valid(pass_valid), .pass_addr(pass_addr),
    .pass_data(pass_data), .armed(armed), .prot_on(prot_on), .id_mode(id_mode),
    .id_rd_valid(id_rd_valid), .id_rd_data(id_rd_data), .erase_start(erase_start),
    .erase_active(erase_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] safe_data(input logic [15:0] a, input logic [7:0] d);
    return (a == 16'h5555 && d == 8'hAA) ? 8'h00 : d;
  endfunction

  // one write cycle; afterwards the registered outputs for it are visible
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit b,
                    input bit exp_pass, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_valid = 1'b0; busy = 1'b0;
    chk(pass_valid == exp_pass, req, pass_valid, exp_pass);
    if (exp_pass) chk(pass_addr == a && pass_data == d, req, {pass_addr, pass_data}, {a, d});
  endtask

  task automatic seq6(input logic [7:0] last, input string req);
    wr(16'h5555, 8'hAA, 0, 0, req);
    wr(16'h2AAA, 8'h55, 0, 0, req);
    wr(16'h5555, 8'h80, 0, 0, req);
    wr(16'h5555, 8'hAA, 0, 0, req);
    wr(16'h2AAA, 8'h55, 0, 0, req);
    wr(16'h5555, last,  0, 0, req);
  endtask

  task automatic id_read(input logic [15:0] a, input bit exp_v, input logic [7:0] exp_d,
                         input string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(id_rd_valid == exp_v, req, id_rd_valid, exp_v);
    if (exp_v) chk(id_rd_data == exp_d, req, id_rd_data, exp_d);
    rd_addr = 16'h8000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(prot_on == 1'b1, "R1", prot_on, 1);
    chk({armed, id_mode, pass_valid, erase_start, erase_active} == 5'b0, "R1",
        {armed, id_mode, pass_valid, erase_start, erase_active}, 0);

    // R2 protected: random ordinary writes are dropped
    for (int i = 0; i < 20; i++) begin
      logic [15:0] a;
      a = 16'($urandom());
      wr(a, safe_data(a, 8'($urandom())), 0, 0, "R2");
    end

    // R3 arm one page load
    wr(16'h5555, 8'hAA, 0, 0, "R3");
    wr(16'h2AAA, 8'h55, 0, 0, "R3");
    wr(16'h5555, 8'hA0, 0, 0, "R3");
    chk(armed && prot_on, "R3", {armed, prot_on}, 2'b11);
    for (int i = 0; i < 4; i++) wr(16'h0300 + 16'(i), 8'(8'h40 + i), 0, 1, "R3");
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0;
    chk(armed == 1'b0, "R3", armed, 0);
    wr(16'h0310, 8'h77, 0, 0, "R2");

    // R4 disable protection, then ordinary writes flow through
    seq6(8'h20, "R5");
    chk(prot_on == 1'b0, "R4", prot_on, 0);
    for (int i = 0; i < 30; i++) begin
      logic [15:0] a;
      a = 16'($urandom());
      wr(a, safe_data(a, 8'($urandom())), 0, 1, "R4");
    end

    // R5 mismatch returns matcher to start; mismatching write forwarded
    wr(16'h5555, 8'hAA, 0, 0, "R5");
    wr(16'h2AAA, 8'h55, 0, 0, "R5");
    wr(16'h1234, 8'h33, 0, 1, "R5");
    wr(16'h2AAA, 8'h55, 0, 1, "R5");

    // R7 busy ignores ordinary write
    wr(16'h0100, 8'h12, 1, 0, "R7");

    // R7/R6 final erase byte collides with busy rising, then retried
    wr(16'h5555, 8'hAA, 0, 0, "R6");
    wr(16'h2AAA, 8'h55, 0, 0, "R6");
    wr(16'h5555, 8'h80, 0, 0, "R6");
    wr(16'h5555, 8'hAA, 0, 0, "R6");
    wr(16'h2AAA, 8'h55, 0, 0, "R6");
    wr(16'h5555, 8'h10, 1, 0, "R7");
    chk(erase_start == 1'b0 && erase_active == 1'b0, "R7", erase_start, 0);
    wr(16'h5555, 8'h10, 0, 0, "R6");
    chk(erase_start == 1'b1 && erase_active == 1'b1, "R6", {erase_start, erase_active}, 2'b11);
    begin
      int n = 0;
      wr_valid = 1'b1; wr_addr = 16'h0200; wr_data = 8'h5A;
      while (erase_active && n < 1000) begin
        n++;
        if (n == 2) chk(erase_start == 1'b0, "R6", erase_start, 0);
        @(negedge clk);
        if (erase_active) chk(pass_valid == 1'b0, "R7", pass_valid, 0);
      end
      wr_valid = 1'b0;
      chk(n == ERASE_N, "R6", n, ERASE_N);
    end

    // R8 ID entry and remapped reads
    seq6(8'h60, "R8");
    chk(id_mode == 1'b1, "R8", id_mode, 1);
    id_read(16'h0000, 1, 8'hDA, "R8");
    id_read(16'h0001, 1, 8'hC8, "R8");
    id_read(16'h0002, 0, 8'h00, "R8");

    // R9 ID exit
    wr(16'h5555, 8'hAA, 0, 0, "R9");
    wr(16'h2AAA, 8'h55, 0, 0, "R9");
    wr(16'h5555, 8'hF0, 0, 0, "R9");
    chk(id_mode == 1'b0, "R9", id_mode, 0);
    id_read(16'h0000, 0, 8'h00, "R9");

    // R3 arm prefix re-enables protection when it was off
    wr(16'h5555, 8'hAA, 0, 0, "R3");
    wr(16'h2AAA, 8'h55, 0, 0, "R3");
    wr(16'h5555, 8'hA0, 0, 0, "R3");
    chk(prot_on == 1'b1, "R3", prot_on, 1);

    // R1 reset again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(prot_on == 1'b1 && armed == 1'b0, "R1", {prot_on, armed}, 2'b10);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule